// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read serial NOR flash as if it were ordinary memory. A read request carries a byte offset into the flash window. The engine then runs one complete serial read sequence on its own and returns a 32-bit word. The sequence has four steps: select a flash device, shift out a read command and the offset, wait out any dummy cycles, and collect four data bytes over one, two or four data lines.

Each chip select has its own setup register, which holds that device's command opcode, address length, dummy length and data-line count. A switch register turns the mapped mode on and names the chip select that the window targets. When the mapped mode is off, or the chosen device has an all-zero setup register, a request is refused at once with an error response. Configuration comes in through a simple write port. The serial clock runs at half the system clock and uses mode 0: it idles low and data is sampled on the rising edge.

Top module: `xip_read_engine`

## Requirements
- R1: Out of reset, all `cs_n` lines are high, `sclk` is low, `io_oe` is zero and `rd_ack` is low.
- R2: A request made while switch bit 0 is clear is answered in the next cycle with `rd_ack` and `rd_err` both high and `rd_data` equal to zero. No chip select falls and `sclk` does not toggle.
- R3: A request aimed at a chip select whose setup register holds zero gets the same immediate error response as in R2, with no serial activity.
- R4: A write with `cfg_sel` MSB set loads the switch register: bit 0 enables the mapped mode and bits [8 +: CS_W] pick the chip select. Only the picked `cs_n` line goes low, it stays low for the whole sequence, and it is high again in the `rd_ack` cycle.
- R5: A write with `cfg_sel` MSB clear loads setup register `cfg_sel[CS_W-1:0]`. Its bits 7:0 hold the opcode, which goes out first on `io_out[0]`, MSB first. `io_oe` is 0001 during the opcode and address bits and 0000 at every other time.
- R6: Setup bits 9:8 plus one give the number of address bytes (1 to 4). The engine sends that many low-order bytes of the offset, MSB first, right after the opcode.
- R7: Setup bits 11:10 give the number of dummy bytes (0 to 3). Each one lasts 8 SCLK cycles, and no line is driven during them.
- R8: Setup bits 13:12 select the data width. Code 0 reads one line (`io_in[1]`), code 1 reads two lines (`io_in[1]` is the more significant bit), code 3 reads four lines (`io_in[3]` is the most significant bit), and code 2 behaves like code 0. Bits arrive MSB first within each byte.
- R9: A successful read returns four consecutive flash bytes, with the lowest address in `rd_data[7:0]`. It is signalled by a single-cycle `rd_ack` with `rd_err` low. The requester drops `rd_req` in the `rd_ack` cycle; a request is not accepted while `rd_ack` is high.
- R10: The setup and switch values are captured when a request is accepted. A configuration write made during a read does not change that read, but it does apply to the next one.
- R11: One read produces exactly 8·(1+A) + 8·D + 32/L rising SCLK edges, where A is the address byte count, D is the dummy byte count and L is the number of data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | CS_W+1 | MSB set: switch register; MSB clear: setup register index |
| cfg_wdata | input | 14 | Configuration write data |
| rd_req | input | 1 | Read request, held until `rd_ack` |
| rd_addr | input | ADDR_W | Byte offset into the flash window |
| rd_ack | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | Error response, valid with `rd_ack` |
| rd_data | output | 32 | Read word, valid with `rd_ack` |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Serial data outputs |
| io_oe | output | 4 | Output enables for `io_out` |
| io_in | input | 4 | Serial data inputs |

## Verification
The bench models a flash device that records every bit sent to it and answers with data computed from the address. Faults in the sequencer therefore show up within a single read at the ports:
- A bad phase counter gives the wrong SCLK edge count, a shifted opcode or address capture, or a misaligned data word.
- A wrong lane setting or byte order corrupts the very first word returned.
- A chip-select decode fault shows up as the wrong line or a line that changes mid-sequence.

The error path is checked for a response exactly one cycle after the request.

// File: rtl/xip_pkg.sv
package xip_pkg;

    typedef struct packed {
        logic [1:0] rtype;
        logic [1:0] ndummy;
        logic [1:0] nadr_m1;
        logic [7:0] opcode;
    } xip_setup_t;

    localparam int SETUP_W = $bits(xip_setup_t);

    typedef enum logic [1:0] {LN_X1, LN_X2, LN_X4} lane_e;

    typedef enum logic [1:0] {S_IDLE, S_TX, S_DUMMY, S_DATA} seq_e;

    function automatic lane_e lane_decode(logic [1:0] rtype);
        case (rtype)
            2'd1:    return LN_X2;
            2'd3:    return LN_X4;
            default: return LN_X1;
        endcase
    endfunction

    // SCLK cycles minus one for the single-line command and address stream
    function automatic logic [5:0] tx_cycles_m1(logic [1:0] nadr_m1);
        return 6'((32'(nadr_m1) + 2) * 8 - 1);
    endfunction

    function automatic logic [5:0] dummy_cycles_m1(logic [1:0] ndummy);
        return 6'(32'(ndummy) * 8 - 1);
    endfunction

    function automatic logic [5:0] data_cycles_m1(lane_e l);
        case (l)
            LN_X2:   return 6'd15;
            LN_X4:   return 6'd7;
            default: return 6'd31;
        endcase
    endfunction

endpackage

// File: rtl/xip_cfg_regs.sv
module xip_cfg_regs
    import xip_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CS_W:0]              cfg_sel,
    input  logic [SETUP_W-1:0]         cfg_wdata,
    output xip_setup_t [NUM_CS-1:0]    setup_o,
    output logic                       mm_en_o,
    output logic [CS_W-1:0]            cs_pick_o
);

    typedef struct packed {
        xip_setup_t [NUM_CS-1:0] setup;
        logic                    en;
        logic [CS_W-1:0]         pick;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_sel[CS_W]) begin
                regs_d.en   = cfg_wdata[0];
                regs_d.pick = cfg_wdata[8 +: CS_W];
            end else begin
                for (int i = 0; i < NUM_CS; i++) begin
                    if (cfg_sel[CS_W-1:0] == CS_W'(i)) begin
                        regs_d.setup[i] = cfg_wdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign setup_o   = regs_q.setup;
    assign mm_en_o   = regs_q.en;
    assign cs_pick_o = regs_q.pick;

endmodule

// File: rtl/xip_lane_rx.sv
module xip_lane_rx
    import xip_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int WORD_W = WORD_BYTES * 8
) (
    input  lane_e              lane,
    input  logic [WORD_W-1:0]  rx_q,
    input  logic [3:0]         io_in,
    output logic [WORD_W-1:0]  rx_next,
    output logic [WORD_W-1:0]  word
);

    always_comb begin
        case (lane)
            LN_X2:   rx_next = {rx_q[WORD_W-3:0], io_in[1:0]};
            LN_X4:   rx_next = {rx_q[WORD_W-5:0], io_in};
            default: rx_next = {rx_q[WORD_W-2:0], io_in[1]};
        endcase
    end

    // first byte received (lowest address) lands in the least significant byte
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_swap
        assign word[8*g +: 8] = rx_next[8*(WORD_BYTES-1-g) +: 8];
    end

endmodule

// File: rtl/xip_seq.sv
module xip_seq
    import xip_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int TX_W  = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               mm_en,
    input  xip_setup_t         cfg,
    input  logic [CS_W-1:0]    cs_pick,
    input  logic [31:0]        rx_next,
    input  logic [31:0]        word,
    output logic               rd_ack,
    output logic               rd_err,
    output logic [31:0]        rd_data,
    output logic               sclk,
    output logic [NUM_CS-1:0]  cs_n,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    output lane_e              lane_o,
    output logic [31:0]        rx_q_o,
    output logic               idle_o
);

    typedef struct packed {
        seq_e              st;
        logic              ph;
        logic [5:0]        cnt;
        logic [TX_W-1:0]   txsh;
        logic [31:0]       rxsh;
        lane_e             lane;
        logic [1:0]        ndum;
        logic [NUM_CS-1:0] cs_n;
        logic              ack;
        logic              err;
        logic [31:0]       data;
    } seq_t;

    seq_t s_d, s_q;
    logic [31:0] addr32;
    logic [31:0] addr_al;

    assign addr32  = 32'(rd_addr);
    assign addr_al = addr32 << (8 * (3 - 32'(cfg.nadr_m1)));

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        s_d.err = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (rd_req && !s_q.ack) begin
                    if (!mm_en || cfg == '0) begin
                        s_d.ack  = 1'b1;
                        s_d.err  = 1'b1;
                        s_d.data = '0;
                    end else begin
                        s_d.st   = S_TX;
                        s_d.ph   = 1'b0;
                        s_d.cnt  = tx_cycles_m1(cfg.nadr_m1);
                        s_d.txsh = {cfg.opcode, addr_al};
                        s_d.lane = lane_decode(cfg.rtype);
                        s_d.ndum = cfg.ndummy;
                        s_d.cs_n = ~(NUM_CS'(1) << cs_pick);
                    end
                end
            end
            default: begin
                if (!s_q.ph) begin
                    s_d.ph = 1'b1;
                end else begin
                    s_d.ph = 1'b0;
                    case (s_q.st)
                        S_TX: begin
                            s_d.txsh = {s_q.txsh[TX_W-2:0], 1'b0};
                            if (s_q.cnt == '0) begin
                                if (s_q.ndum != '0) begin
                                    s_d.st  = S_DUMMY;
                                    s_d.cnt = dummy_cycles_m1(s_q.ndum);
                                end else begin
                                    s_d.st  = S_DATA;
                                    s_d.cnt = data_cycles_m1(s_q.lane);
                                end
                            end else begin
                                s_d.cnt = s_q.cnt - 6'd1;
                            end
                        end
                        S_DUMMY: begin
                            if (s_q.cnt == '0) begin
                                s_d.st  = S_DATA;
                                s_d.cnt = data_cycles_m1(s_q.lane);
                            end else begin
                                s_d.cnt = s_q.cnt - 6'd1;
                            end
                        end
                        default: begin
                            s_d.rxsh = rx_next;
                            if (s_q.cnt == '0) begin
                                s_d.st   = S_IDLE;
                                s_d.cs_n = '1;
                                s_d.ack  = 1'b1;
                                s_d.data = word;
                            end else begin
                                s_d.cnt = s_q.cnt - 6'd1;
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ack  = s_q.ack;
    assign rd_err  = s_q.err;
    assign rd_data = s_q.data;
    assign sclk    = s_q.ph;
    assign cs_n    = s_q.cs_n;
    assign io_out  = {3'b000, (s_q.st == S_TX) & s_q.txsh[TX_W-1]};
    assign io_oe   = {3'b000, s_q.st == S_TX};
    assign lane_o  = s_q.lane;
    assign rx_q_o  = s_q.rxsh;
    assign idle_o  = (s_q.st == S_IDLE);

endmodule

// File: rtl/xip_read_engine.sv
module xip_read_engine
    import xip_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CS_W:0]      cfg_sel,
    input  logic [SETUP_W-1:0] cfg_wdata,
    input  logic               rd_req,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_ack,
    output logic               rd_err,
    output logic [31:0]        rd_data,
    output logic               sclk,
    output logic [NUM_CS-1:0]  cs_n,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);

    xip_setup_t [NUM_CS-1:0] setup_all;
    xip_setup_t              cfg_w;
    logic                    mm_en_w;
    logic [CS_W-1:0]         pick_w;
    lane_e                   lane_w;
    logic [31:0]             rxq_w;
    logic [31:0]             rxn_w;
    logic [31:0]             word_w;
    logic                    seq_idle_w;

    xip_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .setup_o   (setup_all),
        .mm_en_o   (mm_en_w),
        .cs_pick_o (pick_w)
    );

    assign cfg_w = setup_all[pick_w];

    xip_lane_rx #(.WORD_BYTES(4)) u_rx (
        .lane    (lane_w),
        .rx_q    (rxq_w),
        .io_in   (io_in),
        .rx_next (rxn_w),
        .word    (word_w)
    );

    xip_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .mm_en   (mm_en_w),
        .cfg     (cfg_w),
        .cs_pick (pick_w),
        .rx_next (rxn_w),
        .word    (word_w),
        .rd_ack  (rd_ack),
        .rd_err  (rd_err),
        .rd_data (rd_data),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .io_out  (io_out),
        .io_oe   (io_oe),
        .lane_o  (lane_w),
        .rx_q_o  (rxq_w),
        .idle_o  (seq_idle_w)
    );

endmodule

// File: rtl/xip_read_engine_chk.sv
module xip_read_engine_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              rd_err,
    input logic [31:0]       rd_data,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n,
    input logic [3:0]        io_oe,
    input logic              mm_en,
    input logic              idle
);

    a_r1_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    a_r2_off_gives_error: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rd_req && !rd_ack && !mm_en) |=> (rd_ack && rd_err));

    a_r2_error_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> ((&cs_n) && rd_data == 32'd0 && rd_ack));

    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r4_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |=> ((&cs_n) || $stable(cs_n)));

    a_r5_only_line0_driven: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe[3:1] == 3'b000);

    a_r5_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (io_oe == 4'b0000));

    a_r9_ack_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    a_r4_released_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (&cs_n));

endmodule

bind xip_read_engine xip_read_engine_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .rd_err  (rd_err),
    .rd_data (rd_data),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .io_oe   (io_oe),
    .mm_en   (mm_en_w),
    .idle    (seq_idle_w)
);

// File: tb/xip_read_engine_tb_top.sv
module xip_read_engine_tb_top;

    localparam int NCS   = 4;
    localparam int CSW   = 2;
    localparam int AW    = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CSW:0]     cfg_sel = '0;
    logic [13:0]      cfg_wdata = '0;
    logic             rd_req = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic             rd_ack, rd_err, sclk;
    logic [31:0]      rd_data;
    logic [NCS-1:0]   cs_n;
    logic [3:0]       io_out, io_oe;
    logic [3:0]       io_in = 4'b0000;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // flash model state
    int           txn_id = 0;
    int           seen_id = 0;
    int           rcnt = 0;
    int           exp_N = 0, exp_T = 0, exp_L = 1;
    logic [31:0]  exp_addr = '0;
    logic [63:0]  cap_bits = '0;
    bit           oe_bad = 1'b0, cs_bad = 1'b0;
    logic [NCS-1:0] cap_cs = '0;

    always #10 clk = ~clk;

    xip_read_engine #(.NUM_CS(NCS), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data), .sclk(sclk),
        .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] fmem(logic [31:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [13:0] mk_setup(logic [7:0] op, int na_m1, int nd, int rt);
        return {2'(rt), 2'(nd), 2'(na_m1), op};
    endfunction

    function automatic int lanes_of(logic [1:0] rt);
        return (rt == 2'd1) ? 2 : (rt == 2'd3) ? 4 : 1;
    endfunction

    always @(posedge sclk) begin
        if (seen_id != txn_id) begin
            seen_id  = txn_id;
            rcnt     = 0;
            cap_bits = '0;
            oe_bad   = 1'b0;
            cs_bad   = 1'b0;
            cap_cs   = ~cs_n;
        end
        if ((~cs_n) != cap_cs) cs_bad = 1'b1;
        if (rcnt < exp_T) begin
            cap_bits = {cap_bits[62:0], io_out[0]};
            if (io_oe != 4'b0001) oe_bad = 1'b1;
        end else if (io_oe != 4'b0000) begin
            oe_bad = 1'b1;
        end
        rcnt++;
    end

    always @(negedge sclk) begin : flash_out
        int idx, per, k, u;
        logic [7:0] b;
        logic [3:0] v;
        if (seen_id == txn_id && rcnt >= exp_N) begin
            idx = rcnt - exp_N;
            per = 8 / exp_L;
            k   = idx / per;
            u   = idx % per;
            b   = fmem(exp_addr + 32'(k));
            v   = 4'((32'(b) >> (8 - (u + 1) * exp_L)) & ((1 << exp_L) - 1));
            case (exp_L)
                1:       io_in = {2'b00, v[0], 1'b0};
                2:       io_in = {2'b00, v[1:0]};
                default: io_in = v;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [CSW:0] sel, input logic [13:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic select_cs(input int cs, input bit en);
        cfg_write({1'b1, 2'b00}, 14'((cs << 8) | int'(en)));
    endtask

    task automatic do_read(input int cs, input logic [AW-1:0] addr, input logic [13:0] setup,
                           input bit exp_err, input string tag,
                           input bit mid_wr, input logic [13:0] mid_val);
        int cyc, nab, nd, edges;
        logic [63:0] exp_cmd, mask;
        logic [31:0] exp_word, got;
        logic got_err;
        nab = int'(setup[9:8]) + 1;
        nd  = int'(setup[11:10]);
        @(negedge clk);
        exp_L    = lanes_of(setup[13:12]);
        exp_T    = 8 + 8 * nab;
        exp_N    = exp_T + 8 * nd;
        exp_addr = 32'(addr);
        txn_id++;
        rd_addr  = addr;
        rd_req   = 1'b1;
        cyc      = 0;
        got      = '0;
        got_err  = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (mid_wr && cyc == 7) cfg_we = 1'b0;
            if (rd_ack) begin
                got = rd_data; got_err = rd_err; rd_req = 1'b0;
                break;
            end
            if (mid_wr && cyc == 6) begin
                cfg_we = 1'b1; cfg_sel = {1'b0, 2'(cs)}; cfg_wdata = mid_val;
            end
            if (cyc > 2000) begin
                chk(1'b0, {tag, " R9 no ack"}, 64'(cyc), 64'd0);
                rd_req = 1'b0;
                break;
            end
        end
        cfg_we = 1'b0;
        edges = (seen_id == txn_id) ? rcnt : 0;
        if (exp_err) begin
            chk(cyc == 1, {tag, " R2/R3 error latency"}, 64'(cyc), 64'd1);
            chk(got_err == 1'b1 && got == 32'd0, {tag, " R2/R3 error response"},
                {31'd0, got_err, got}, {31'd0, 1'b1, 32'd0});
            chk(edges == 0, {tag, " R2/R3 no serial activity"}, 64'(edges), 64'd0);
        end else begin
            exp_word = {fmem(exp_addr + 3), fmem(exp_addr + 2), fmem(exp_addr + 1), fmem(exp_addr)};
            mask     = (64'd1 << (8 * nab)) - 64'd1;
            exp_cmd  = (64'(setup[7:0]) << (8 * nab)) | (64'(addr) & mask);
            chk(got_err == 1'b0 && got == exp_word, {tag, " R9/R8 data word"},
                {31'd0, got_err, got}, {32'd0, exp_word});
            chk(cap_bits == exp_cmd, {tag, " R5/R6 opcode and address"}, cap_bits, exp_cmd);
            chk(edges == exp_N + 32 / exp_L, {tag, " R11/R7 sclk edge count"},
                64'(edges), 64'(exp_N + 32 / exp_L));
            chk(!oe_bad, {tag, " R5/R7 output enable"}, 64'(oe_bad), 64'd0);
            chk(!cs_bad && cap_cs == NCS'(1 << cs) && (&cs_n), {tag, " R4 chip select"},
                64'({cs_bad, cap_cs}), 64'(1 << cs));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [13:0] s;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == '1 && !sclk && io_oe == 4'b0 && !rd_ack, "R1 reset state",
            64'({cs_n, sclk, io_oe, rd_ack}), 64'({4'hF, 1'b0, 4'h0, 1'b0}));

        // R2 mapped mode off
        cfg_write({1'b0, 2'd0}, mk_setup(8'h03, 2, 0, 0));
        select_cs(0, 1'b0);
        do_read(0, 24'h000123, mk_setup(8'h03, 2, 0, 0), 1'b1, "R2 switch off", 1'b0, '0);

        // R3 zero setup register
        select_cs(2, 1'b1);
        do_read(2, 24'h000040, 14'd0, 1'b1, "R3 zero setup", 1'b0, '0);

        // directed: single, dual, quad, code 2, widest and narrowest framing
        s = mk_setup(8'h03, 2, 0, 0);
        cfg_write({1'b0, 2'd0}, s); select_cs(0, 1'b1);
        do_read(0, 24'h12_3456, s, 1'b0, "R8 single", 1'b0, '0);
        s = mk_setup(8'h3B, 2, 1, 1);
        cfg_write({1'b0, 2'd1}, s); select_cs(1, 1'b1);
        do_read(1, 24'hAB_CDE0, s, 1'b0, "R8 dual", 1'b0, '0);
        s = mk_setup(8'h6B, 2, 1, 3);
        cfg_write({1'b0, 2'd3}, s); select_cs(3, 1'b1);
        do_read(3, 24'h00_0FFD, s, 1'b0, "R8 quad", 1'b0, '0);
        s = mk_setup(8'h0B, 0, 0, 2);
        cfg_write({1'b0, 2'd2}, s); select_cs(2, 1'b1);
        do_read(2, 24'h00_00F7, s, 1'b0, "R8 code2 single R6 one byte", 1'b0, '0);
        s = mk_setup(8'hEC, 3, 3, 3);
        cfg_write({1'b0, 2'd2}, s);
        do_read(2, 24'hFF_FFFC, s, 1'b0, "R6 four bytes R7 three dummies", 1'b0, '0);

        // R10 write during a read
        s = mk_setup(8'h13, 3, 1, 1);
        cfg_write({1'b0, 2'd1}, s); select_cs(1, 1'b1);
        do_read(1, 24'h55_AA55, s, 1'b0, "R10 latched", 1'b1, mk_setup(8'hBB, 1, 2, 3));
        do_read(1, 24'h00_1234, mk_setup(8'hBB, 1, 2, 3), 1'b0, "R10 next read", 1'b0, '0);

        // random
        for (int i = 0; i < 40; i++) begin
            int cs;
            logic [AW-1:0] a;
            cs = $urandom_range(0, 3);
            a  = AW'($urandom);
            if ($urandom_range(0, 9) == 0) s = 14'd0;
            else s = mk_setup(8'($urandom_range(1, 255)), $urandom_range(0, 3),
                              $urandom_range(0, 3), $urandom_range(0, 3));
            cfg_write({1'b0, 2'(cs)}, s);
            select_cs(cs, 1'b1);
            do_read(cs, a, s, s == 14'd0, "R9 random", 1'b0, '0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule